// File: doc/BRIEF.md
# UART Line Status Unit

This block builds the eight-bit line status byte of a 16550-style serial port. On the receive side it keeps a queue of received characters. Every character is stored with its own parity, framing and break tags, so the status byte always describes the character that the CPU will read next. A summary bit stays high while any queued character still carries a tag. The summary comes from a counter of tagged entries, so it needs no scan of the queue.

On the transmit side the block tracks how full the transmit queue is. It combines that count with the shift register's empty indication to produce the holding-empty and transmitter-empty flags. It also produces the holding-empty interrupt request. A single mode input chooses between deep queues and single-entry holding registers. The serial shifters and the baud clock lie outside the block: they only hand over strobes and one status bit.

Top module: `uart_lsr_core`

## Requirements
- R1: Bit 0 of `lsr` is 1 exactly when the receive queue holds at least one character. A `rd_data` strobe removes the oldest character, and `rx_head` shows the oldest stored character whenever bit 0 is 1.
- R2: Bit 2 (parity) and bit 3 (framing) of `lsr` equal the tags of the oldest stored character. Both read 0 when the queue is empty, and both follow the next character after a pop.
- R3: Bit 7 of `lsr` is 1 while any stored character carries a parity, framing or break tag. It returns to 0 once the last tagged character is popped. A push and a pop in the same cycle are both counted.
- R4: While the queue runs in deep mode, a run of consecutive break strobes (`rx_valid` with `rx_brk`) stores only one entry, until a strobe with `rx_brk`=0 arrives. In single-entry mode every break strobe is stored.
- R5: Bit 4 of `lsr` is the break tag of the oldest stored character. It is masked after an `rd_lsr` strobe that sees that character, and the mask ends when that character is popped.
- R6: A receive strobe that finds the queue full, with no pop in the same cycle, is discarded and sets bit 1 of `lsr`. An `rd_lsr` strobe clears bit 1. A new overrun in the same cycle as the read wins.
- R7: With `fifo_en`=1 each queue holds `RX_DEPTH` or `TX_DEPTH` characters (32 by default). With `fifo_en`=0 each queue holds one character.
- R8: Bit 5 of `lsr` is 1 exactly when the transmit queue is empty. A `wr_thr` strobe stores a character unless the queue is full and no `tsr_load` happens in the same cycle. A `tsr_load` removes one character if any are stored.
- R9: Bit 6 of `lsr` is 1 only when the transmit queue is empty and `tsr_empty` is 1.
- R10: `tx_irq` is 1 exactly when `thr_ie` is 1 and bit 5 of `lsr` is 1.
- R11: A change of `fifo_en` empties both queues, clears the error count, the break mask and the break run state, and ignores all pushes, pops and writes in that cycle.
- R12: After reset, with `tsr_empty`=1, `lsr` reads 8'h60 and `tx_irq` follows `thr_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 selects deep queues, 0 selects single-entry holding registers |
| rx_valid | input | 1 | Receiver delivers one character |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity of the delivered character was wrong |
| rx_ferr | input | 1 | Stop bit of the delivered character was missing |
| rx_brk | input | 1 | Delivered character is a break (line low for a whole frame) |
| rd_data | input | 1 | CPU reads the receive data register |
| rd_lsr | input | 1 | CPU reads the status register |
| wr_thr | input | 1 | CPU writes a transmit character |
| tsr_load | input | 1 | Shift register takes one character from the transmit queue |
| tsr_empty | input | 1 | Shift register holds no character |
| thr_ie | input | 1 | Holding-empty interrupt enable |
| lsr | output | 8 | Status byte |
| rx_head | output | 8 | Oldest stored received character |
| tx_irq | output | 1 | Holding-empty interrupt request |

## Verification
The bench goes after the cycles where the error count moves both ways at once. A pop of a tagged character together with a push of a clean one must drop the summary bit, and a counter that handled only one event per cycle would leave bit 7 stuck high. It sends bursts of break strobes: a design that does not collapse them fills the queue with break entries, and one that collapses them in single-entry mode loses characters. Overflow is driven at exactly the full boundary in both modes, where an off-by-one accepts a 33rd character or refuses the 32nd. Mode changes are made with data queued, where a missing flush leaves stale entries and a wrong ready flag.

// File: rtl/uls_pkg.sv
// Package: shared types for the UART line status unit.
// Assumes an eight-bit character; the tags travel with each stored character.
package uls_pkg;
    localparam int ULS_DW = 8;

    typedef struct packed {
        logic [ULS_DW-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_ent_t;

    // True when the entry carries any error tag.
    function automatic logic ent_tagged(input rx_ent_t e);
        return e.perr | e.ferr | e.brk;
    endfunction
endpackage

// File: rtl/uls_rx_fifo.sv
// Receive queue: a circular buffer of tagged characters plus a count of the
// entries that carry a tag. Capacity is DEPTH, or one entry when cap_one is set.
// Assumes a flush is only requested when the capacity changes.
module uls_rx_fifo
    import uls_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    flush,
    input  logic    cap_one,
    input  logic    push_req,
    input  rx_ent_t push_ent,
    input  logic    pop_req,
    output rx_ent_t head_ent,
    output logic    not_empty,
    output logic    push_ok,
    output logic    pop_fire,
    output logic    err_any
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_N = CW'(DEPTH);
    localparam logic [CW-1:0] ONE_N  = CW'(1);

    rx_ent_t         mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   cnt, err_cnt, cap;
    logic            tag_in, tag_out;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cap       = cap_one ? ONE_N : FULL_N;
    assign not_empty = (cnt != '0);
    assign pop_fire  = pop_req && not_empty && !flush;
    assign push_ok   = push_req && !flush && ((cnt < cap) || pop_fire);
    assign head_ent  = mem[rd_ptr];
    assign err_any   = (err_cnt != '0);
    assign tag_in    = push_ok && ent_tagged(push_ent);
    assign tag_out   = pop_fire && ent_tagged(head_ent);

    // Store an accepted character at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_ent;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok)  wr_ptr <= ptr_next(wr_ptr);
            if (pop_fire) rd_ptr <= ptr_next(rd_ptr);
            cnt <= cnt + CW'(push_ok) - CW'(pop_fire);
        end
    end

    // Count the stored entries that carry a tag; both events may land together.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) err_cnt <= '0;
        else                 err_cnt <= err_cnt + CW'(tag_in) - CW'(tag_out);
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_N);

    // R3
    err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= cnt);

    // R1
    push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !pop_fire) |=> (cnt == CW'($past(cnt) + 1'b1)));
endmodule

// File: rtl/uls_rx_ctrl.sv
// Receive control: it collapses runs of break strobes, keeps the sticky overrun
// flag and the break mask set by a status read. Assumes push_ok and
// pop_fire come from the receive queue in the same cycle.
module uls_rx_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic fifo_en,
    input  logic rx_valid,
    input  logic rx_brk,
    input  logic push_ok,
    input  logic pop_fire,
    input  logic rd_lsr,
    input  logic head_brk,
    input  logic not_empty,
    output logic push_req,
    output logic overrun,
    output logic brk_ack
);
    logic brk_active;
    logic run_brk;

    assign run_brk  = rx_valid && rx_brk && fifo_en && !flush;
    assign push_req = rx_valid && !(fifo_en && rx_brk && brk_active);

    // Remember that a break run is in progress until a normal character arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) brk_active <= 1'b0;
        else if (rx_valid)   brk_active <= rx_brk && fifo_en;
    end

    // Sticky overrun: a refused push sets it, a status read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 overrun <= 1'b0;
        else if (push_req && !push_ok && !flush)    overrun <= 1'b1;
        else if (rd_lsr)                            overrun <= 1'b0;
    end

    // Mask the head break tag once software has seen it in the status byte.
    always_ff @(posedge clk) begin
        if (!rst_n || flush || pop_fire)                 brk_ack <= 1'b0;
        else if (rd_lsr && not_empty && head_brk)        brk_ack <= 1'b1;
    end

    // R4
    brk_collapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_brk ##1 run_brk |-> !push_req);

    // R6
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !push_ok && !flush) |=> overrun);

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_fire |=> !brk_ack);
endmodule

// File: rtl/uls_tx_track.sv
// Transmit tracking: it counts the characters waiting for the shift register and
// derives the holding-empty, transmitter-empty and interrupt outputs.
// Assumes a flush is only requested when the capacity changes.
module uls_tx_track #(
    parameter int DEPTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic cap_one,
    input  logic wr_req,
    input  logic load_req,
    input  logic tsr_empty,
    input  logic irq_en,
    output logic thre,
    output logic temt,
    output logic irq
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_N = CW'(DEPTH);
    localparam logic [CW-1:0] ONE_N  = CW'(1);

    logic [CW-1:0] cnt, cap;
    logic          ld_fire, wr_ok;

    assign cap     = cap_one ? ONE_N : FULL_N;
    assign ld_fire = load_req && (cnt != '0) && !flush;
    assign wr_ok   = wr_req && !flush && ((cnt < cap) || ld_fire);
    assign thre    = (cnt == '0);
    assign temt    = thre && tsr_empty;
    assign irq     = thre && irq_en;

    // Track how many characters wait for the shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) cnt <= '0;
        else                 cnt <= cnt + CW'(wr_ok) - CW'(ld_fire);
    end

    // R8
    thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !flush) |=> !thre);

    // R7
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_N);
endmodule

// File: rtl/uart_lsr_core.sv
// Top of the line status unit: it detects mode changes, wires the receive queue,
// receive control and transmit tracker together and assembles the status byte.
// Assumes single-cycle strobes from the CPU side and from the shifters.
module uart_lsr_core
    import uls_pkg::*;
#(
    parameter int RX_DEPTH = 32,
    parameter int TX_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              rx_valid,
    input  logic [ULS_DW-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              rd_data,
    input  logic              rd_lsr,
    input  logic              wr_thr,
    input  logic              tsr_load,
    input  logic              tsr_empty,
    input  logic              thr_ie,
    output logic [7:0]        lsr,
    output logic [ULS_DW-1:0] rx_head,
    output logic              tx_irq
);
    logic    mode_q, flush;
    rx_ent_t push_ent, head_ent;
    logic    not_empty, push_ok, pop_fire, err_any;
    logic    push_req, overrun, brk_ack;
    logic    thre, temt;

    assign flush    = (mode_q != fifo_en);
    assign push_ent = '{data: rx_data, perr: rx_perr, ferr: rx_ferr, brk: rx_brk};

    // Remember the previous mode so that a change can flush both queues.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= fifo_en;
    end

    uls_rx_fifo #(.DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .cap_one  (!fifo_en),
        .push_req (push_req),
        .push_ent (push_ent),
        .pop_req  (rd_data),
        .head_ent (head_ent),
        .not_empty(not_empty),
        .push_ok  (push_ok),
        .pop_fire (pop_fire),
        .err_any  (err_any)
    );

    uls_rx_ctrl u_rx_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .fifo_en  (fifo_en),
        .rx_valid (rx_valid),
        .rx_brk   (rx_brk),
        .push_ok  (push_ok),
        .pop_fire (pop_fire),
        .rd_lsr   (rd_lsr),
        .head_brk (head_ent.brk),
        .not_empty(not_empty),
        .push_req (push_req),
        .overrun  (overrun),
        .brk_ack  (brk_ack)
    );

    uls_tx_track #(.DEPTH(TX_DEPTH)) u_tx_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .cap_one  (!fifo_en),
        .wr_req   (wr_thr),
        .load_req (tsr_load),
        .tsr_empty(tsr_empty),
        .irq_en   (thr_ie),
        .thre     (thre),
        .temt     (temt),
        .irq      (tx_irq)
    );

    assign rx_head = head_ent.data;
    assign lsr = {err_any,
                  temt,
                  thre,
                  head_ent.brk  & not_empty & !brk_ack,
                  head_ent.ferr & not_empty,
                  head_ent.perr & not_empty,
                  overrun,
                  not_empty};

    // R3
    err_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lsr[7] |-> !(lsr[2] | lsr[3] | lsr[4]));
endmodule

// File: tb/uart_lsr_core_tb.sv
module uart_lsr_core_tb;
    localparam int DEPTH = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic       rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rd_data = 1'b0, rd_lsr = 1'b0, wr_thr = 1'b0, tsr_load = 1'b0;
    logic       tsr_empty = 1'b1, thr_ie = 1'b0;
    logic [7:0] lsr, rx_head;
    logic       tx_irq;

    uart_lsr_core #(.RX_DEPTH(DEPTH), .TX_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
        .rd_data(rd_data), .rd_lsr(rd_lsr), .wr_thr(wr_thr), .tsr_load(tsr_load),
        .tsr_empty(tsr_empty), .thr_ie(thr_ie), .lsr(lsr), .rx_head(rx_head),
        .tx_irq(tx_irq)
    );

    always #4 clk = ~clk;

    int nchk = 0, nbad = 0, ncyc = 0;
    bit done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    endtask

    // Behavioural reference model
    typedef struct { logic [7:0] d; bit p; bit f; bit b; } ent_t;
    ent_t q[$];
    bit   m_ovr, m_ack, m_brk, m_mode;
    int   m_tx;
    bit   fl, pop, preq, acc, ovf, tld, twr;
    int   cap;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_ovr = 0; m_ack = 0; m_brk = 0; m_mode = 0; m_tx = 0;
        end else begin
            fl = (fifo_en != m_mode);
            m_mode = fifo_en;
            if (fl) begin
                q.delete(); m_tx = 0; m_brk = 0; m_ack = 0;
                if (rd_lsr) m_ovr = 0;
            end else begin
                cap  = fifo_en ? DEPTH : 1;
                pop  = rd_data && q.size() > 0;
                preq = rx_valid && !(fifo_en && rx_brk && m_brk);
                acc  = preq && (q.size() < cap || pop);
                ovf  = preq && !acc;
                if (pop) m_ack = 0;
                else if (rd_lsr && q.size() > 0 && q[0].b) m_ack = 1;
                if (rx_valid) m_brk = rx_brk && fifo_en;
                if (pop) q.delete(0);
                if (acc) q.push_back('{rx_data, rx_perr, rx_ferr, rx_brk});
                tld  = tsr_load && m_tx > 0;
                twr  = wr_thr && (m_tx < cap || tld);
                m_tx = m_tx + int'(twr) - int'(tld);
                if (ovf) m_ovr = 1;
                else if (rd_lsr) m_ovr = 0;
            end
        end
    end

    // Compare every output against the model on each falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit any_tag;
            bit ne;
            any_tag = 0;
            foreach (q[i]) if (q[i].p || q[i].f || q[i].b) any_tag = 1;
            ne = q.size() > 0;
            chk("R1 ready", lsr[0], ne);
            if (ne) chk("R1 head data", rx_head, q[0].d);
            chk("R2 parity", lsr[2], ne && q[0].p);
            chk("R2 framing", lsr[3], ne && q[0].f);
            chk("R3 summary", lsr[7], any_tag);
            chk("R5 break", lsr[4], ne && q[0].b && !m_ack);
            chk("R6 overrun", lsr[1], m_ovr);
            chk("R8 holding empty", lsr[5], m_tx == 0);
            chk("R9 tx empty", lsr[6], (m_tx == 0) && tsr_empty);
            chk("R10 irq", tx_irq, thr_ie && (m_tx == 0));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 150000) begin
            nbad++;
            $display("FAIL watchdog: run did not finish");
            report();
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        rx_valid = 0; rd_data = 0; rd_lsr = 0; wr_thr = 0; tsr_load = 0;
        rx_perr = 0; rx_ferr = 0; rx_brk = 0;
    endtask

    task automatic push(input logic [7:0] d, input bit p, input bit f, input bit b);
        rx_valid = 1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
        tick();
    endtask

    task automatic pop1();
        rd_data = 1; tick();
    endtask

    task automatic rdstat();
        rd_lsr = 1; tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R12 reset state
        chk("R12 reset lsr", lsr, 8'h60);
        chk("R12 reset irq", tx_irq, 0);

        // R1 plain characters
        push(8'h11, 0, 0, 0); push(8'h22, 0, 0, 0); push(8'h33, 0, 0, 0);
        chk("R1 ready after push", lsr[0], 1);
        chk("R1 head first", rx_head, 8'h11);
        pop1(); chk("R1 head second", rx_head, 8'h22);
        pop1(); pop1();
        chk("R1 empty", lsr[0], 0);

        // R2 / R3 tags per entry
        push(8'h40, 1, 0, 0); push(8'h41, 0, 0, 0); push(8'h42, 0, 1, 0);
        chk("R2 head parity", lsr[2], 1);
        chk("R3 summary set", lsr[7], 1);
        pop1();
        chk("R2 parity follows head", lsr[2], 0);
        chk("R3 summary kept", lsr[7], 1);
        pop1();
        chk("R2 framing head", lsr[3], 1);
        rx_valid = 1; rx_data = 8'h43; rd_data = 1; tick();
        chk("R3 summary clear on push+pop", lsr[7], 0);
        pop1();

        // R4 / R5 break collapse and mask
        repeat (4) push(8'h00, 0, 1, 1);
        push(8'h55, 0, 0, 0);
        chk("R5 break shown", lsr[4], 1);
        rdstat();
        chk("R5 break masked", lsr[4], 0);
        chk("R3 summary while masked", lsr[7], 1);
        pop1();
        chk("R4 one break entry", rx_head, 8'h55);
        chk("R4 ready", lsr[0], 1);
        pop1();
        chk("R4 queue empty", lsr[0], 0);

        // R6 / R7 overflow at depth
        for (int i = 0; i <= DEPTH; i++) push(8'(i), 0, 0, 0);
        chk("R6 overrun set", lsr[1], 1);
        rdstat();
        chk("R6 overrun cleared", lsr[1], 0);
        repeat (DEPTH - 1) pop1();
        chk("R7 last entry", rx_head, 8'(DEPTH - 1));
        chk("R7 still ready", lsr[0], 1);
        pop1();
        chk("R7 drained", lsr[0], 0);

        // R8 / R9 / R10 transmit side
        wr_thr = 1; tick();
        chk("R8 holding full", lsr[5], 0);
        chk("R9 tx busy", lsr[6], 0);
        thr_ie = 1; #1;
        chk("R10 irq low", tx_irq, 0);
        tsr_load = 1; tsr_empty = 0; tick();
        chk("R8 holding empty", lsr[5], 1);
        chk("R9 shifter busy", lsr[6], 0);
        chk("R10 irq high", tx_irq, 1);
        tsr_empty = 1; #1;
        chk("R9 all empty", lsr[6], 1);
        for (int i = 0; i <= DEPTH; i++) begin wr_thr = 1; tick(); end
        repeat (DEPTH - 1) begin tsr_load = 1; tick(); end
        chk("R8 one left", lsr[5], 0);
        tsr_load = 1; tick();
        chk("R8 extra write ignored", lsr[5], 1);
        thr_ie = 0;

        // R11 mode change flush, then single-entry mode
        push(8'h01, 0, 0, 0); push(8'h02, 1, 0, 0);
        wr_thr = 1; tick(); wr_thr = 1; tick();
        fifo_en = 0; tick();
        chk("R11 rx flushed", lsr[0], 0);
        chk("R11 tx flushed", lsr[5], 1);
        chk("R11 summary cleared", lsr[7], 0);
        push(8'hA1, 0, 0, 0); push(8'hA2, 0, 0, 0);
        chk("R7 single overrun", lsr[1], 1);
        chk("R7 single head", rx_head, 8'hA1);
        rdstat(); pop1();
        push(8'h00, 0, 0, 1); pop1(); push(8'h00, 0, 0, 1);
        chk("R4 single mode keeps break", lsr[0], 1);
        pop1();
        wr_thr = 1; tick(); wr_thr = 1; tick();
        tsr_load = 1; tick();
        chk("R7 single tx slot", lsr[5], 1);
        fifo_en = 1; tick();

        // Random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            rx_valid = ($urandom_range(0, 99) < 50);
            rx_data  = 8'($urandom);
            rx_perr  = ($urandom_range(0, 99) < 15);
            rx_ferr  = ($urandom_range(0, 99) < 10);
            rx_brk   = ($urandom_range(0, 99) < 12);
            rd_data  = ($urandom_range(0, 99) < 45);
            rd_lsr   = ($urandom_range(0, 99) < 20);
            wr_thr   = ($urandom_range(0, 99) < 40);
            tsr_load = ($urandom_range(0, 99) < 40);
            tsr_empty = ($urandom_range(0, 99) < 50);
            thr_ie   = ($urandom_range(0, 99) < 50);
            if ($urandom_range(0, 299) == 0) fifo_en = ~fifo_en;
            tick();
        end
        tick();
        report();
    end
endmodule